// File: doc/BRIEF.md
# Codec Register Access Controller

This block sits on a 32-bit word-addressed register bus and lets a processor carry out single register accesses to an external audio codec. Software loads a codec register address and, for writes, an outgoing data word. It then writes the control word with the go bit set and a direction bit that selects a codec write or a codec read. The block hands the access to the codec side through a request/acknowledge handshake. That handshake stands in for the serial link, which lives elsewhere.

When the codec acknowledges, the block raises a one-cycle interrupt pulse. A completed codec write pulses the request-done interrupt. A completed codec read pulses the reply interrupt, and the returned value is already in the data-in register when that pulse is high. The go bit never reads back as set. A busy flag in the control word shows that an access is still outstanding, and any go written during that time is dropped.

Top module: `codec_regacc`

## Requirements
- R1: After reset every register reads zero, `cdc_req` is low and both interrupt outputs are low.
- R2: The registers sit at word indices 0 (control), 1 (codec address), 2 (data out) and 3 (data in), at byte offsets 0, 4, 8 and 12. Indices 1 to 3 read back the full 32-bit value last written.
- R3: A control write with bit 0 (go) set and bit 1 (direction) set starts a codec write. `cdc_req` rises in the next cycle with `cdc_we`=1, `cdc_addr` set to the low bits of the codec address register and `cdc_wdata` set to the low bits of the data-out register. A control write with go set and direction clear starts a codec read in the same way, with `cdc_we`=0.
- R4: When the acknowledge of a codec write is sampled, `cdc_req` drops and `irq_creq` is high for exactly the one following cycle. `irq_crep` stays low.
- R5: When the acknowledge of a codec read is sampled, `cdc_rdata` (zero-extended) is stored into the data-in register and `irq_crep` is high for exactly one cycle. The new data-in value is readable from that same cycle. If a bus write to data-in falls on the same edge, the codec data wins.
- R6: The control word reads back as the value last written with bit 0 forced to 0. Bits 1 and 3 to 31 are kept, and bit 2 shows the busy state.
- R7: Control bit 2 reads 1 from the cycle after an accepted go until the acknowledge is sampled. A go written while busy starts nothing and adds no interrupt pulse.
- R8: An access with byte enables other than 4'hF, or with a byte address that is not a multiple of 4, is not accepted. A write changes nothing and starts nothing, and a read returns zero.
- R9: A read of any word index from 4 upward returns zero, and a write there has no effect on any register.
- R10: A control write with bit 0 clear starts no codec access and raises no interrupt.
- R11: `cdc_ack` is ignored while no access is outstanding. It produces no interrupt and leaves data-in unchanged.
- R12: While an access waits for acknowledge, `cdc_we`, `cdc_addr` and `cdc_wdata` hold the values latched at the start, even if the address or data-out register is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq_creq | output | 1 | One-cycle pulse when a codec write completes |
| irq_crep | output | 1 | One-cycle pulse when a codec read completes |
| cdc_req | output | 1 | Codec access outstanding |
| cdc_we | output | 1 | Direction of the outstanding access, 1 = write |
| cdc_addr | output | CAW | Codec register address |
| cdc_wdata | output | CDW | Data for a codec write |
| cdc_ack | input | 1 | Codec acknowledge |
| cdc_rdata | input | CDW | Codec read data, valid with `cdc_ack` |

## Verification
The bench aims at a go bit written while an access is still waiting. A design that accepted it would emit an extra pulse or swap the direction or address in mid-access. It rewrites the address and data-out registers during a wait: a design that drove the codec pins straight from those registers would show the new values on the pins. It also drives a stray acknowledge with nothing outstanding, which a careless design turns into a phantom interrupt or a corrupted data-in. Partial byte enables, misaligned addresses and out-of-range indices are exercised too; a loose decoder would show these as altered registers or nonzero read data.

// File: rtl/cacc_pkg.sv
package cacc_pkg;
    localparam int          NREG      = 4;
    localparam int          REG_IDX_W = $clog2(NREG);
    localparam int          BUS_W     = 32;
    localparam logic [3:0]  BE_FULL   = 4'hF;

    localparam logic [REG_IDX_W-1:0] IDX_CTRL  = 2'd0;
    localparam logic [REG_IDX_W-1:0] IDX_CADDR = 2'd1;
    localparam logic [REG_IDX_W-1:0] IDX_DOUT  = 2'd2;
    localparam logic [REG_IDX_W-1:0] IDX_DIN   = 2'd3;

    localparam int CB_GO   = 0;
    localparam int CB_DIR  = 1;
    localparam int CB_BUSY = 2;

    // bits the control register stores; go and busy are never stored
    localparam logic [BUS_W-1:0] CTRL_KEEP = ~((BUS_W'(1) << CB_GO) | (BUS_W'(1) << CB_BUSY));
endpackage

// File: rtl/cacc_decode.sv
module cacc_decode
    import cacc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [3:0]           bus_be,
    output logic [NREG-1:0]      wr_stb,
    output logic                 rd_stb,
    output logic [REG_IDX_W-1:0] rd_idx
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             hit;

    always_comb begin
        word_idx = bus_addr[ADDR_W-1:2];
        hit      = bus_sel && (bus_be == BE_FULL) && (bus_addr[1:0] == 2'b00)
                   && (word_idx < IDX_W'(NREG));
        rd_stb   = hit && !bus_we;
        rd_idx   = word_idx[REG_IDX_W-1:0];
    end

    for (genvar i = 0; i < NREG; i++) begin : g_wstb
        assign wr_stb[i] = hit && bus_we && (word_idx == IDX_W'(i));
    end
endmodule

// File: rtl/cacc_regs.sv
module cacc_regs
    import cacc_pkg::*;
#(
    parameter int CAW = 7,
    parameter int CDW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREG-1:0]      wr_stb,
    input  logic [BUS_W-1:0]     wdata,
    input  logic                 rd_stb,
    input  logic [REG_IDX_W-1:0] rd_idx,
    input  logic                 busy,
    input  logic                 cap_en,
    input  logic [CDW-1:0]       cap_data,
    output logic [BUS_W-1:0]     rdata,
    output logic                 go,
    output logic                 go_wr,
    output logic [CAW-1:0]       caddr_o,
    output logic [CDW-1:0]       dout_o
);
    typedef struct packed {
        logic [BUS_W-1:0] ctrl;
        logic [BUS_W-1:0] caddr;
        logic [BUS_W-1:0] dout;
        logic [BUS_W-1:0] din;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_stb[IDX_CTRL])  r_d.ctrl  = wdata & CTRL_KEEP;
        if (wr_stb[IDX_CADDR]) r_d.caddr = wdata;
        if (wr_stb[IDX_DOUT])  r_d.dout  = wdata;
        if (wr_stb[IDX_DIN])   r_d.din   = wdata;
        // codec read data takes priority over a bus write in the same cycle
        if (cap_en)            r_d.din   = BUS_W'(cap_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_stb) begin
            case (rd_idx)
                IDX_CTRL:  rdata = r_q.ctrl | (BUS_W'(busy) << CB_BUSY);
                IDX_CADDR: rdata = r_q.caddr;
                IDX_DOUT:  rdata = r_q.dout;
                default:   rdata = r_q.din;
            endcase
        end
    end

    assign go      = wr_stb[IDX_CTRL] && wdata[CB_GO];
    assign go_wr   = wdata[CB_DIR];
    assign caddr_o = r_q.caddr[CAW-1:0];
    assign dout_o  = r_q.dout[CDW-1:0];

    // R5: a captured codec value is what data-in holds afterwards
    assert_din_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (r_q.din == $past(BUS_W'(cap_data))));

    // R6: control readback never shows the go bit
    assert_go_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_idx == IDX_CTRL) |-> !rdata[CB_GO]);
endmodule

// File: rtl/cacc_link.sv
module cacc_link #(
    parameter int CAW = 7,
    parameter int CDW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           start_wr,
    input  logic [CAW-1:0] src_addr,
    input  logic [CDW-1:0] src_data,
    input  logic           cdc_ack,
    input  logic [CDW-1:0] cdc_rdata,
    output logic           cdc_req,
    output logic           cdc_we,
    output logic [CAW-1:0] cdc_addr,
    output logic [CDW-1:0] cdc_wdata,
    output logic           busy,
    output logic           irq_w,
    output logic           irq_r,
    output logic           cap_en,
    output logic [CDW-1:0] cap_data
);
    typedef struct packed {
        logic           pend;
        logic           dir_wr;
        logic           irq_w;
        logic           irq_r;
        logic [CAW-1:0] addr;
        logic [CDW-1:0] data;
    } link_t;

    link_t l_d, l_q;

    always_comb begin
        l_d       = l_q;
        l_d.irq_w = 1'b0;
        l_d.irq_r = 1'b0;
        if (l_q.pend && cdc_ack) begin
            l_d.pend = 1'b0;
            if (l_q.dir_wr) l_d.irq_w = 1'b1;
            else            l_d.irq_r = 1'b1;
        end
        // a go that arrives while an access is outstanding is dropped
        if (start && !l_q.pend) begin
            l_d.pend   = 1'b1;
            l_d.dir_wr = start_wr;
            l_d.addr   = src_addr;
            l_d.data   = src_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign cdc_req   = l_q.pend;
    assign cdc_we    = l_q.dir_wr;
    assign cdc_addr  = l_q.addr;
    assign cdc_wdata = l_q.data;
    assign busy      = l_q.pend;
    assign irq_w     = l_q.irq_w;
    assign irq_r     = l_q.irq_r;
    assign cap_en    = l_q.pend && cdc_ack && !l_q.dir_wr;
    assign cap_data  = cdc_rdata;

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cdc_req && !cdc_ack) |=> (cdc_req && $stable(cdc_we) && $stable(cdc_addr) && $stable(cdc_wdata)));

    assert_wpulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_w |=> !irq_w);

    assert_rpulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_r |=> !irq_r);

    assert_irq_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_w, irq_r}));

    assert_irq_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_w || irq_r) |-> $past(cdc_req && cdc_ack));

    assert_stray_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cdc_req |=> !(irq_w || irq_r));

    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cdc_req && !cdc_ack) |=> (cdc_req && $stable(cdc_we)));
endmodule

// File: rtl/codec_regacc.sv
module codec_regacc
    import cacc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CAW    = 7,
    parameter int CDW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_creq,
    output logic              irq_crep,
    output logic              cdc_req,
    output logic              cdc_we,
    output logic [CAW-1:0]    cdc_addr,
    output logic [CDW-1:0]    cdc_wdata,
    input  logic              cdc_ack,
    input  logic [CDW-1:0]    cdc_rdata
);
    logic [NREG-1:0]      wr_stb;
    logic                 rd_stb;
    logic [REG_IDX_W-1:0] rd_idx;
    logic                 busy, cap_en, go, go_wr;
    logic [CDW-1:0]       cap_data, dout_v;
    logic [CAW-1:0]       caddr_v;

    cacc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .bus_be  (bus_be),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .rd_idx  (rd_idx)
    );

    cacc_regs #(.CAW(CAW), .CDW(CDW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wdata   (bus_wdata),
        .rd_stb  (rd_stb),
        .rd_idx  (rd_idx),
        .busy    (busy),
        .cap_en  (cap_en),
        .cap_data(cap_data),
        .rdata   (bus_rdata),
        .go      (go),
        .go_wr   (go_wr),
        .caddr_o (caddr_v),
        .dout_o  (dout_v)
    );

    cacc_link #(.CAW(CAW), .CDW(CDW)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (go),
        .start_wr (go_wr),
        .src_addr (caddr_v),
        .src_data (dout_v),
        .cdc_ack  (cdc_ack),
        .cdc_rdata(cdc_rdata),
        .cdc_req  (cdc_req),
        .cdc_we   (cdc_we),
        .cdc_addr (cdc_addr),
        .cdc_wdata(cdc_wdata),
        .busy     (busy),
        .irq_w    (irq_creq),
        .irq_r    (irq_crep),
        .cap_en   (cap_en),
        .cap_data (cap_data)
    );

    // R8: rejected accesses never reach a register
    assert_partial_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_be != 4'hF) |-> (wr_stb == '0 && bus_rdata == '0));
endmodule

// File: tb/codec_regacc_tb.sv
module codec_regacc_tb;
    localparam int AW = 6, CAW = 7, CDW = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           bus_sel = 0, bus_we = 0;
    logic [AW-1:0]  bus_addr = '0;
    logic [3:0]     bus_be = 4'hF;
    logic [31:0]    bus_wdata = '0, bus_rdata;
    logic           irq_creq, irq_crep, cdc_req, cdc_we;
    logic [CAW-1:0] cdc_addr;
    logic [CDW-1:0] cdc_wdata;
    logic           cdc_ack = 1'b0;
    logic [CDW-1:0] cdc_rdata = '0;

    codec_regacc #(.ADDR_W(AW), .CAW(CAW), .CDW(CDW)) u_dut (.*);

    int errors = 0, checks = 0;
    int n_iw = 0, n_ir = 0;
    int ack_delay = 0, wcnt = 0;
    bit spur = 0;
    logic [15:0] resp = 16'h1A2B, last_resp = 16'h0;

    // behavioural reference state
    logic [31:0] m_ctrl, m_addr, m_dout, m_din, m_la, m_lw, oa, od;
    bit m_pend, m_dir, m_iw, m_ir, was_pend, ok_wr;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_addr = 0; m_dout = 0; m_din = 0; m_la = 0; m_lw = 0;
            m_pend = 0; m_dir = 0; m_iw = 0; m_ir = 0;
        end else begin
            was_pend = m_pend; oa = m_addr; od = m_dout;
            m_iw = 0; m_ir = 0;
            ok_wr = bus_sel && bus_we && bus_be == 4'hF && bus_addr[1:0] == 2'b00;
            if (m_pend && cdc_ack) begin
                m_pend = 0;
                if (m_dir) m_iw = 1; else m_ir = 1;
            end
            if (ok_wr) begin
                case (int'(bus_addr) / 4)
                    0: begin
                        m_ctrl = bus_wdata & 32'hFFFF_FFFA;
                        if (bus_wdata[0] && !was_pend) begin
                            m_pend = 1; m_dir = bus_wdata[1]; m_la = oa; m_lw = od;
                        end
                    end
                    1: m_addr = bus_wdata;
                    2: m_dout = bus_wdata;
                    3: m_din  = bus_wdata;
                    default: ;
                endcase
            end
            if (m_ir) m_din = {16'h0, cdc_rdata};
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            #3;
            chk("R3 cdc_req", cdc_req, m_pend);
            if (m_pend) begin
                chk("R3 cdc_we", cdc_we, m_dir);
                chk("R12 cdc_addr", cdc_addr, m_la[CAW-1:0]);
                chk("R12 cdc_wdata", cdc_wdata, m_lw[CDW-1:0]);
            end
            chk("R4 irq_creq", irq_creq, m_iw);
            chk("R5 irq_crep", irq_crep, m_ir);
            if (irq_creq) n_iw++;
            if (irq_crep) n_ir++;
        end
    end

    // codec-side responder
    always @(negedge clk) begin
        if (!rst_n) begin
            cdc_ack = 0; wcnt = 0;
        end else if (cdc_req && !cdc_ack) begin
            if (wcnt >= ack_delay) begin
                cdc_ack = 1; cdc_rdata = resp; last_resp = resp;
                resp = resp + 16'h1357; wcnt = 0;
            end else wcnt++;
        end else cdc_ack = spur;
    end

    task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_be = 4'hF;
    endtask

    task automatic bus_rd(logic [AW-1:0] a, logic [31:0] exp, string tag, logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a; bus_be = be;
        #2;
        chk(tag, bus_rdata, exp);
        @(negedge clk);
        bus_sel = 0; bus_be = 4'hF;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 60 && cdc_req; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 cdc_req", cdc_req, 0);
        chk("R1 irq", {irq_creq, irq_crep}, 0);
        bus_rd(0,  0, "R1 ctrl");
        bus_rd(4,  0, "R1 caddr");
        bus_rd(8,  0, "R1 dout");
        bus_rd(12, 0, "R1 din");

        // R2: register map and readback
        bus_wr(4, 32'h0000_002A);
        bus_wr(8, 32'hBEEF_1234);
        bus_wr(12, 32'h0BAD_F00D);
        bus_rd(4,  32'h0000_002A, "R2 caddr");
        bus_rd(8,  32'hBEEF_1234, "R2 dout");
        bus_rd(12, 32'h0BAD_F00D, "R2 din");

        // R3/R4/R6/R7: codec write with a slow acknowledge
        ack_delay = 3; n_iw = 0; n_ir = 0;
        bus_wr(0, 32'h0000_00F3);
        bus_rd(0, 32'h0000_00F6, "R7 busy readback");
        wait_done();
        bus_rd(0, 32'h0000_00F2, "R6 selfclear");
        chk("R4 write pulses", n_iw, 1);
        chk("R4 no reply pulse", n_ir, 0);

        // R5: codec read
        ack_delay = 0; n_iw = 0; n_ir = 0;
        bus_wr(0, 32'h0000_0001);
        wait_done();
        bus_rd(12, {16'h0, last_resp}, "R5 din capture");
        bus_rd(0, 32'h0, "R6 ctrl after read");
        chk("R5 reply pulses", n_ir, 1);
        chk("R5 no write pulse", n_iw, 0);

        // R7/R12: go while busy and register rewrites mid-access
        ack_delay = 6; n_iw = 0; n_ir = 0;
        bus_wr(0, 32'h0000_0003);
        bus_wr(4, 32'h0000_0055);
        bus_wr(8, 32'h0000_9999);
        bus_wr(0, 32'h0000_0001);
        wait_done();
        chk("R7 single write pulse", n_iw, 1);
        chk("R7 no extra reply", n_ir, 0);
        ack_delay = 1; n_ir = 0;
        bus_wr(0, 32'h0000_0001);
        wait_done();
        chk("R7 next access accepted", n_ir, 1);

        // R10: control write without go
        n_iw = 0; n_ir = 0;
        bus_wr(0, 32'h0000_0002);
        repeat (5) @(negedge clk);
        chk("R10 no pulses", n_iw + n_ir, 0);
        bus_rd(0, 32'h0000_0002, "R10 ctrl stored");

        // R11: stray acknowledge
        bus_wr(12, 32'h0000_CAFE);
        spur = 1;
        repeat (2) @(negedge clk);
        spur = 0;
        repeat (2) @(negedge clk);
        chk("R11 no pulses", n_iw + n_ir, 0);
        bus_rd(12, 32'h0000_CAFE, "R11 din untouched");

        // R8: partial or misaligned accesses
        bus_wr(4, 32'h0000_0077, 4'h3);
        bus_rd(4, 32'h0000_0055, "R8 partial write ignored");
        bus_rd(4, 32'h0, "R8 partial read zero", 4'hC);
        bus_rd(5, 32'h0, "R8 misaligned read zero");
        bus_wr(0, 32'h0000_0003, 4'h1);
        repeat (4) @(negedge clk);
        chk("R8 no access started", n_iw + n_ir, 0);
        bus_rd(0, 32'h0000_0002, "R8 ctrl unchanged");

        // R9: undefined offsets
        bus_wr(28, 32'hDEAD_BEEF);
        bus_wr(60, 32'h0000_0003);
        repeat (4) @(negedge clk);
        chk("R9 no access started", n_iw + n_ir, 0);
        bus_rd(28, 32'h0, "R9 undefined read zero");
        bus_rd(4,  32'h0000_0055, "R9 caddr intact");
        bus_rd(8,  32'h0000_9999, "R9 dout intact");
        bus_rd(12, 32'h0000_CAFE, "R9 din intact");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule